// File: doc/BRIEF.md
# Interleaved Longword Memory Sequencer

This block sits between a processor core and a memory whose every location is a 16-bit word. The core asks for one of two transfer sizes, a single byte or a 32-bit longword, and the block turns the request into one or two accesses on a single 16-bit memory port. A byte occupies only the low half of one word. A longword spans two adjacent word addresses, and its four bytes are interleaved across those two words rather than laid end to end. The same interleaving applies to any pointer the core keeps in memory.

The core presents a request with a write flag, a size flag, a word address and write data. It then waits for a one-cycle ready pulse, which comes with the read result when the request was a read. The memory side has registered outputs: an access strobe, a write enable, an address and write data. Read data is expected one cycle after the strobe and address. A longword may begin at any word address, and the address of the second word wraps round at the top of the address space.

Top module: `lw_mem_seq`

## Requirements
- R1: After reset, the ready output, the memory strobe and the memory write enable are all 0.
- R2: A byte read performs exactly one memory read at the request address. The result is that word's low 8 bits, zero-extended to 32 bits. The word's high 8 bits have no effect on the result.
- R3: A byte write performs exactly one memory write at the request address. The written word is {8'hFF, wdata[7:0]}.
- R4: A longword read fetches word A and then word A+1. With word A = {p,q} and word A+1 = {r,s}, where each letter is a byte and the high byte is written first, the result is {r,p,s,q}.
- R5: A longword write stores {wdata[23:16], wdata[7:0]} at address A first. It then stores {wdata[31:24], wdata[15:8]} at address A+1.
- R6: A longword can start at an odd word address. It then behaves exactly as one that starts at an even address, and a value written there reads back unchanged.
- R7: A longword that starts at address 32'hFFFFFFFF uses 32'h00000000 as its second word address.
- R8: Ready is high for exactly one cycle per transfer. It rises on the third clock edge after a byte request is accepted, counting the accepting edge, and on the fourth edge after a longword request is accepted.
- R9: A request is accepted only when the block is idle. A request held while a transfer is in flight starts no memory access and changes neither the address nor the data of the transfer already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = 32-bit longword, 0 = byte |
| req_addr | input | 32 | Word address of the first location |
| req_wdata | input | 32 | Write data (a byte uses bits 7:0) |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result; loaded at completion of a read |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the strobe |

## Verification
The bench raises a request just before an edge and counts the edges from that accepting edge onward. Ready is due at edge three for a byte and at edge four for a longword. The bench samples on each falling edge after acceptance, so the pulse is seen in exactly the half-period the requirement names, and the sample one cycle later confirms that it has dropped. The bench's memory model logs every strobed access. Order, address and data are therefore checked against the log once the transfer ends, and the log stays open through two further idle cycles, so that any access started by a held request would be recorded.

// File: rtl/lw_mem_pkg.sv
package lw_mem_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2,
      ST_LAST   = 2'd3
   } seq_st_e;

   localparam int unsigned LANES_PER_WORD = 2;

endpackage

// File: rtl/lw_seq_ctrl.sv
module lw_seq_ctrl
   import lw_mem_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    req_long,
   output seq_st_e state_o,
   output logic    accept_o,
   output logic    issue_second_o,
   output logic    cap_low_o,
   output logic    finish_o
);

   seq_st_e state_q, state_d;
   logic    long_q;

   assign accept_o       = (state_q == ST_IDLE) && req_valid;
   assign issue_second_o = (state_q == ST_FIRST) && long_q;
   assign cap_low_o      = (state_q == ST_SECOND);
   assign finish_o       = (state_q == ST_LAST);
   assign state_o        = state_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (req_valid) state_d = ST_FIRST;
         ST_FIRST:  state_d = long_q ? ST_SECOND : ST_LAST;
         ST_SECOND: state_d = ST_LAST;
         ST_LAST:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         long_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept_o) long_q <= req_long;
      end
   end

   // R8: a transfer always passes through LAST exactly once, then idles
   p_last_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LAST) |=> (state_q == ST_IDLE));

   // R9: while busy, state advances without returning to FIRST
   p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> (state_q != ST_FIRST));

endmodule

// File: rtl/lw_word_split.sv
module lw_word_split #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned BYTE_FILL = 255,
   localparam int unsigned LANE_W   = WORD_W / 2,
   localparam int unsigned DATA_W   = 2 * WORD_W
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              long_i,
   output logic [WORD_W-1:0] first_o,
   output logic [WORD_W-1:0] second_o
);

   localparam logic [LANE_W-1:0] FILL = LANE_W'(BYTE_FILL);

   logic [WORD_W-1:0] long_first, long_second;

   // Longword lanes: even data lanes go to the first word, odd to the second.
   for (genvar i = 0; i < 2; i++) begin : g_lane
      assign long_first [i*LANE_W +: LANE_W] = data_i[(2*i)*LANE_W   +: LANE_W];
      assign long_second[i*LANE_W +: LANE_W] = data_i[(2*i+1)*LANE_W +: LANE_W];
   end

   assign first_o  = long_i ? long_first : {FILL, data_i[LANE_W-1:0]};
   assign second_o = long_second;

endmodule

// File: rtl/lw_word_merge.sv
module lw_word_merge #(
   parameter int unsigned WORD_W        = 16,
   parameter bit          BYTE_SIGN_EXT = 1'b0,
   localparam int unsigned LANE_W       = WORD_W / 2,
   localparam int unsigned DATA_W       = 2 * WORD_W
) (
   input  logic [WORD_W-1:0] first_i,
   input  logic [WORD_W-1:0] last_i,
   input  logic              long_i,
   output logic [DATA_W-1:0] data_o
);

   logic [DATA_W-1:0] long_val;
   logic [DATA_W-1:0] byte_val;

   for (genvar i = 0; i < 2; i++) begin : g_lane
      assign long_val[(2*i)*LANE_W   +: LANE_W] = first_i[i*LANE_W +: LANE_W];
      assign long_val[(2*i+1)*LANE_W +: LANE_W] = last_i [i*LANE_W +: LANE_W];
   end

   // For a byte, the single word arrives on last_i; its upper lane is dropped.
   if (BYTE_SIGN_EXT) begin : g_sext
      assign byte_val = {{(DATA_W-LANE_W){last_i[LANE_W-1]}}, last_i[LANE_W-1:0]};
   end else begin : g_zext
      assign byte_val = {{(DATA_W-LANE_W){1'b0}}, last_i[LANE_W-1:0]};
   end

   assign data_o = long_i ? long_val : byte_val;

endmodule

// File: rtl/lw_mem_seq.sv
module lw_mem_seq
   import lw_mem_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned WORD_W        = 16,
   parameter int unsigned BYTE_FILL     = 255,
   parameter bit          BYTE_SIGN_EXT = 1'b0,
   localparam int unsigned LANE_W       = WORD_W / 2,
   localparam int unsigned DATA_W       = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_long,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata
);

   if (WORD_W % 2 != 0 || WORD_W < 2) begin : g_bad_word
      $error("lw_mem_seq: WORD_W must be even and at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("lw_mem_seq: ADDR_W too small");
   end
   if (BYTE_FILL >= (1 << LANE_W)) begin : g_bad_fill
      $error("lw_mem_seq: BYTE_FILL exceeds one lane");
   end

   seq_st_e state;
   logic    accept, issue_second, cap_low, finish;

   lw_seq_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_long      (req_long),
      .state_o       (state),
      .accept_o      (accept),
      .issue_second_o(issue_second),
      .cap_low_o     (cap_low),
      .finish_o      (finish)
   );

   logic [WORD_W-1:0] split_first, split_second;

   lw_word_split #(.WORD_W(WORD_W), .BYTE_FILL(BYTE_FILL)) u_split (
      .data_i  (req_wdata),
      .long_i  (req_long),
      .first_o (split_first),
      .second_o(split_second)
   );

   logic [ADDR_W-1:0] addr_q;
   logic              write_q, long_q;
   logic [WORD_W-1:0] second_q;
   logic [WORD_W-1:0] low_q;
   logic [DATA_W-1:0] merged;

   lw_word_merge #(.WORD_W(WORD_W), .BYTE_SIGN_EXT(BYTE_SIGN_EXT)) u_merge (
      .first_i(low_q),
      .last_i (mem_rdata),
      .long_i (long_q),
      .data_o (merged)
   );

   // Request capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         write_q  <= 1'b0;
         long_q   <= 1'b0;
         second_q <= '0;
      end else if (accept) begin
         addr_q   <= req_addr;
         write_q  <= req_write;
         long_q   <= req_long;
         second_q <= split_second;
      end
   end

   // Memory port: first word on accept, second word one cycle later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_en    <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (accept) begin
         mem_en    <= 1'b1;
         mem_we    <= req_write;
         mem_addr  <= req_addr;
         mem_wdata <= split_first;
      end else if (issue_second) begin
         mem_en    <= 1'b1;
         mem_we    <= write_q;
         mem_addr  <= addr_q + ADDR_W'(1);
         mem_wdata <= second_q;
      end else begin
         mem_en    <= 1'b0;
         mem_we    <= 1'b0;
      end
   end

   // Read return and completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q     <= '0;
         rsp_ready <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (cap_low) low_q <= mem_rdata;
         rsp_ready <= finish;
         if (finish && !write_q) rsp_rdata <= merged;
      end
   end

   // R1: reset leaves the ports quiet
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!rsp_ready && !mem_en && !mem_we));

   // R3: byte writes carry the fill pattern in the upper lane
   p_byte_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && !long_q && state == ST_FIRST)
      |-> (mem_wdata[WORD_W-1:LANE_W] == LANE_W'(BYTE_FILL)));

   // R7: second word address is the first plus one, modulo the address width
   p_next_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SECOND) |-> (mem_en && mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))));

   // R8: ready is a single-cycle pulse
   p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !rsp_ready);

   // R9: no memory access while the last word returns
   p_last_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LAST) |-> !mem_en);

   // R9: the in-flight address is held while busy
   p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_FIRST) |-> $stable(addr_q));

endmodule

// File: tb/lw_mem_seq_tb.sv
module lw_mem_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_long = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        rsp_ready;
   logic [31:0] rsp_rdata;
   logic        mem_en, mem_we;
   logic [31:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5ns clk = ~clk;

   lw_mem_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_long(req_long),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // Memory model with access log
   logic [15:0] mem_q [logic [31:0]];
   logic        log_we   [64];
   logic [31:0] log_addr [64];
   logic [15:0] log_data [64];
   int          op_n = 0;

   always @(posedge clk) begin
      if (mem_en) begin
         if (op_n < 64) begin
            log_we[op_n]   <= mem_we;
            log_addr[op_n] <= mem_addr;
            log_data[op_n] <= mem_we ? mem_wdata : 16'h0;
         end
         op_n <= op_n + 1;
         if (mem_we) mem_q[mem_addr] = mem_wdata;
         else mem_rdata <= mem_q.exists(mem_addr) ? mem_q[mem_addr] : 16'h0000;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Issue one transfer; returns read data, ready position and pulse count.
   task automatic xfer(input bit wr, input bit lg, input logic [31:0] a, input logic [31:0] d,
                       input bit junk, output logic [31:0] rd, output int base,
                       output int rdy_at, output int rdy_cnt);
      rdy_at = 0; rdy_cnt = 0; rd = '0;
      @(negedge clk);
      base = op_n;
      req_valid = 1'b1; req_write = wr; req_long = lg; req_addr = a; req_wdata = d;
      @(posedge clk);
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (junk && rdy_at == 0) begin
            req_addr = ~a; req_wdata = ~d; req_write = ~wr; req_long = ~lg;
         end else begin
            req_valid = 1'b0;
         end
         if (rsp_ready) begin
            rdy_cnt++;
            if (rdy_at == 0) begin
               rdy_at = k; rd = rsp_rdata; req_valid = 1'b0;
            end
         end
      end
   endtask

   task automatic t_reset();
      check(rsp_ready == 1'b0, "R1 ready", {31'b0, rsp_ready}, 32'h0);
      check(mem_en == 1'b0 && mem_we == 1'b0, "R1 strobe", {30'b0, mem_en, mem_we}, 32'h0);
   endtask

   task automatic t_byte_read();
      logic [31:0] rd; int b, at, cnt;
      mem_q[32'h0000_1234] = 16'hA55C;
      xfer(1'b0, 1'b0, 32'h0000_1234, 32'h0, 1'b0, rd, b, at, cnt);
      check(rd == 32'h0000_005C, "R2 byte data", rd, 32'h5C);
      check(op_n - b == 1 && log_addr[b] == 32'h1234 && !log_we[b], "R2 one read", log_addr[b], 32'h1234);
      check(at == 3, "R8 byte latency", at, 3);
      check(cnt == 1, "R8 byte pulse", cnt, 1);
   endtask

   task automatic t_byte_write();
      logic [31:0] rd; int b, at, cnt;
      xfer(1'b1, 1'b0, 32'h0000_0040, 32'h1234_56C3, 1'b0, rd, b, at, cnt);
      check(op_n - b == 1, "R3 one write", op_n - b, 1);
      check(log_we[b] && log_data[b] == 16'hFFC3 && log_addr[b] == 32'h40, "R3 word", {16'h0, log_data[b]}, 32'hFFC3);
   endtask

   task automatic t_long_read();
      logic [31:0] rd; int b, at, cnt;
      mem_q[32'h100] = 16'hAABB;
      mem_q[32'h101] = 16'hCCDD;
      xfer(1'b0, 1'b1, 32'h100, 32'h0, 1'b0, rd, b, at, cnt);
      check(rd == 32'hCCAA_DDBB, "R4 long data", rd, 32'hCCAADDBB);
      check(log_addr[b] == 32'h100 && log_addr[b+1] == 32'h101 && op_n - b == 2, "R4 order", log_addr[b+1], 32'h101);
      check(at == 4 && cnt == 1, "R8 long latency", at, 4);
   endtask

   task automatic t_long_write_odd();
      logic [31:0] rd; int b, at, cnt;
      xfer(1'b1, 1'b1, 32'h2001, 32'h1122_3344, 1'b0, rd, b, at, cnt);
      check(log_addr[b] == 32'h2001 && log_data[b] == 16'h2244, "R5 first word", {16'h0, log_data[b]}, 32'h2244);
      check(log_addr[b+1] == 32'h2002 && log_data[b+1] == 16'h1133, "R5 second word", {16'h0, log_data[b+1]}, 32'h1133);
      xfer(1'b0, 1'b1, 32'h2001, 32'h0, 1'b0, rd, b, at, cnt);
      check(rd == 32'h1122_3344, "R6 odd readback", rd, 32'h11223344);
   endtask

   task automatic t_wrap();
      logic [31:0] rd; int b, at, cnt;
      xfer(1'b1, 1'b1, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 1'b0, rd, b, at, cnt);
      check(log_addr[b] == 32'hFFFF_FFFF && log_data[b] == 16'hADEF, "R7 first", log_addr[b], 32'hFFFFFFFF);
      check(log_addr[b+1] == 32'h0 && log_data[b+1] == 16'hDEBE, "R7 wrap addr", log_addr[b+1], 32'h0);
      xfer(1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, rd, b, at, cnt);
      check(rd == 32'hDEAD_BEEF, "R7 readback", rd, 32'hDEADBEEF);
   endtask

   task automatic t_busy();
      logic [31:0] rd; int b, at, cnt;
      xfer(1'b1, 1'b1, 32'h300, 32'h0A0B_0C0D, 1'b1, rd, b, at, cnt);
      check(op_n - b == 2, "R9 op count", op_n - b, 2);
      check(log_addr[b] == 32'h300 && log_data[b] == 16'h0B0D, "R9 first kept", {16'h0, log_data[b]}, 32'h0B0D);
      check(log_addr[b+1] == 32'h301 && log_data[b+1] == 16'h0A0C && log_we[b+1], "R9 second kept", {16'h0, log_data[b+1]}, 32'h0A0C);
      check(cnt == 1, "R8 pulse under hold", cnt, 1);
      mem_q[32'h500] = 16'h7F11;
      xfer(1'b0, 1'b0, 32'h500, 32'h0, 1'b1, rd, b, at, cnt);
      check(op_n - b == 1 && rd == 32'h11, "R9 byte under hold", rd, 32'h11);
   endtask

   initial begin
      #(200000 * 5ns);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_byte_read();
      t_byte_write();
      t_long_read();
      t_long_write_odd();
      t_wrap();
      t_busy();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule